// File: doc/BRIEF.md
# Filterless Differential PWM Modulator

This block turns a signed audio sample for each of two channels into a pair of pulse-width-modulated drive signals, P and N, for the two halves of a full bridge. No reconstruction filter is needed after it. When the sample is zero, P and N are the same waveform. Both switch in phase at half duty, so the voltage across the load is zero for almost the whole period. A positive sample widens the P pulse and narrows the N pulse by the same amount. A negative sample does the opposite. Both pulses stay centred on the carrier period boundary.

An up/down carrier counter sets the switching period. With the frequency-select input high, the period is fixed at twice `HALF` clock cycles. At the default parameters that is 256 cycles, which gives 300 kHz from a 76.8 MHz clock. With it low, a 16-bit LFSR moves the turning point of the counter by an offset between -8 and +7 counts. The offset is chosen once per period, which spreads the switching spectrum. At each period boundary the block latches three things at once: the samples, the mono select and the frequency select. Changing an input mid-period therefore never alters a pulse that is already running.

In mono mode both bridge pairs take the right-channel sample, so they switch in lockstep. A drive-enable input controls the bridge pad enable, and disabling it parks every data output low. After each period the block reports the signed difference between the P and N duties of that period, for a downstream DC-fault monitor.

Top module: `fpwm_bridge_mod`

## Requirements
- R1: While reset is held, all four PWM outputs, `bridge_oe`, `dd_valid`, `dd_l` and `dd_r` are zero.
- R2: With a latched sample of zero, the P and N outputs of that channel are identical in every cycle, and each is high for exactly half of the period.
- R3: In each period, with the sample s taken as two's complement (bit 7 is the sign) and the period being 2M cycles, P is high for clamp(M+s, 0, 2M) cycles and N is high for clamp(M-s, 0, 2M) cycles.
- R4: A pulse of duty d occupies the first ceil(d/2) and the last floor(d/2) cycles of its period, so it is centred on the period boundary.
- R5: With `freq_fixed` high at a period boundary, the following period lasts exactly 2*HALF clock cycles.
- R6: With `freq_fixed` low at a period boundary, the following period lasts 2*(HALF+k) cycles, with k between -8 and +7 taken from a pseudo-random sequence. The length varies from period to period, and R3 holds against the actual length.
- R7: A change of a sample input in the middle of a period has no effect on that period's pulses. It takes effect from the next period.
- R8: With `mono` high, the left pair is driven from `samp_r`: its outputs and its reported difference equal those of the right pair.
- R9: One cycle after `enable` falls, `bridge_oe` is low and all four data outputs are low, and they stay so while `enable` is low. One cycle after `enable` rises, `bridge_oe` is high again.
- R10: At each period end, `dd_valid` is high for exactly one cycle. In that cycle `dd_l` and `dd_r` hold, as signed values, the P duty minus the N duty of the period just ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Bridge drive enable |
| freq_fixed | input | 1 | High: fixed period; low: dithered period |
| mono | input | 1 | High: both pairs follow the right sample |
| samp_l | input | SAMP_W | Left sample, two's complement |
| samp_r | input | SAMP_W | Right sample, two's complement |
| pwm_lp | output | 1 | Left P drive |
| pwm_ln | output | 1 | Left N drive |
| pwm_rp | output | 1 | Right P drive |
| pwm_rn | output | 1 | Right N drive |
| bridge_oe | output | 1 | Pad output enable; low requests high impedance |
| dd_l | output | CNT_W+2 | Left signed duty difference of the last period |
| dd_r | output | CNT_W+2 | Right signed duty difference of the last period |
| dd_valid | output | 1 | One-cycle strobe at each period end |

## Verification
The bench builds the block with `CNT_W`=6 and `HALF`=32, so a fixed period is only 64 cycles. Every one of the 256 sample codes can then be swept on both channels, with the per-cycle pulse shape compared to the arithmetic expectation. Because the 8-bit sample range is four times the half period, clamping at both zero and full duty is reached across much of the sweep. The ±8 dither is a quarter of the half period, so it produces clearly different period lengths within a few dozen periods.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } cdir_e;
endpackage

// File: rtl/fpwm_carrier.sv
module fpwm_carrier
  import fpwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int HALF    = 128,
  parameter int DITH_W  = 4,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fix_i,
  output logic [CNT_W-1:0] t_o,
  output logic [CNT_W-1:0] m_o,
  output cdir_e            dir_o,
  output logic             bound_o
);
  localparam int MLO = HALF - 2**(DITH_W-1);
  localparam int MHI = HALF + 2**(DITH_W-1) - 1;

  logic [CNT_W-1:0]  t_q, m_q, m_nx, off_ext;
  cdir_e             dir_q;
  logic [LFSR_W-1:0] lfsr_q, lfsr_nx;
  logic              bound;

  assign bound = (dir_q == DIR_DN) && (t_q == '0);

  always_comb begin
    lfsr_nx = lfsr_q >> 1;
    if (lfsr_q[0]) lfsr_nx = lfsr_nx ^ TAPS;
  end

  assign off_ext = {{(CNT_W-DITH_W){lfsr_q[DITH_W-1]}}, lfsr_q[DITH_W-1:0]};
  assign m_nx    = fix_i ? CNT_W'(HALF) : CNT_W'(HALF) + off_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= '0;
      dir_q  <= DIR_UP;
      m_q    <= CNT_W'(HALF);
      lfsr_q <= SEED;
    end else if (bound) begin
      t_q    <= '0;
      dir_q  <= DIR_UP;
      m_q    <= m_nx;
      lfsr_q <= lfsr_nx;
    end else if (dir_q == DIR_UP) begin
      if (t_q == m_q - 1'b1) dir_q <= DIR_DN;
      else                   t_q   <= t_q + 1'b1;
    end else begin
      t_q <= t_q - 1'b1;
    end
  end

  assign t_o     = t_q;
  assign m_o     = m_q;
  assign dir_o   = dir_q;
  assign bound_o = bound;

  AST_CNT_BELOW_TOP: assert property (@(posedge clk) disable iff (rst)
    t_q < m_q);  // R5
  AST_TURN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dir_q == DIR_UP && t_q == m_q - 1'b1) |=> (dir_q == DIR_DN && t_q == $past(t_q)));  // R4
  AST_M_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (m_q >= CNT_W'(MLO)) && (m_q <= CNT_W'(MHI)));  // R6
endmodule

// File: rtl/fpwm_chan.sv
module fpwm_chan
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SAMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_i,
  input  logic                     en_i,
  input  logic signed [SAMP_W-1:0] samp_i,
  input  logic [CNT_W-1:0]         m_i,
  input  logic [CNT_W-1:0]         t_i,
  input  cdir_e                    dir_i,
  output logic                     p_o,
  output logic                     n_o,
  output logic signed [CNT_W+1:0]  dd_o
);
  localparam int DW = CNT_W + 1;

  logic signed [SAMP_W-1:0] s_q;
  logic [DW-1:0]            dp, dn, kup, kdp, kun, kdn;
  logic [DW-1:0]            t_ext;
  logic                     p_cmp, n_cmp;
  logic                     p_q, n_q;
  logic signed [DW:0]       dd_q;
  int                       mi, si, pi, ni;

  always_comb begin
    mi = int'(m_i);
    si = int'(s_q);
    pi = mi + si;
    ni = mi - si;
    if (pi < 0) pi = 0; else if (pi > 2*mi) pi = 2*mi;
    if (ni < 0) ni = 0; else if (ni > 2*mi) ni = 2*mi;
    dp = DW'(pi);
    dn = DW'(ni);
  end

  assign kup   = (dp >> 1) + {{(DW-1){1'b0}}, dp[0]};
  assign kdp   = dp >> 1;
  assign kun   = (dn >> 1) + {{(DW-1){1'b0}}, dn[0]};
  assign kdn   = dn >> 1;
  assign t_ext = {1'b0, t_i};
  assign p_cmp = (dir_i == DIR_UP) ? (t_ext < kup) : (t_ext < kdp);
  assign n_cmp = (dir_i == DIR_UP) ? (t_ext < kun) : (t_ext < kdn);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q  <= '0;
      p_q  <= 1'b0;
      n_q  <= 1'b0;
      dd_q <= '0;
    end else begin
      p_q <= en_i & p_cmp;
      n_q <= en_i & n_cmp;
      if (load_i) begin
        s_q  <= samp_i;
        dd_q <= $signed({1'b0, dp}) - $signed({1'b0, dn});
      end
    end
  end

  assign p_o  = p_q;
  assign n_o  = n_q;
  assign dd_o = dd_q;

  AST_DUTY_SUM: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, dp} + {1'b0, dn}) == {1'b0, m_i, 1'b0});  // R3
  AST_ZERO_INPHASE: assert property (@(posedge clk) disable iff (rst)
    (s_q == '0) |=> (p_q == n_q));  // R2
endmodule

// File: rtl/fpwm_bridge_mod.sv
module fpwm_bridge_mod
  import fpwm_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int HALF   = 128,
  parameter int SAMP_W = 8,
  parameter int DITH_W = 4,
  parameter int LFSR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic                    freq_fixed,
  input  logic                    mono,
  input  logic [SAMP_W-1:0]       samp_l,
  input  logic [SAMP_W-1:0]       samp_r,
  output logic                    pwm_lp,
  output logic                    pwm_ln,
  output logic                    pwm_rp,
  output logic                    pwm_rn,
  output logic                    bridge_oe,
  output logic [CNT_W+1:0]        dd_l,
  output logic [CNT_W+1:0]        dd_r,
  output logic                    dd_valid
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] t_w, m_w;
  cdir_e            dir_w;
  logic             bound_w;
  logic             oe_q, ddv_q, mono_q;

  logic signed [SAMP_W-1:0] ch_samp [NCH];
  logic                     p_w     [NCH];
  logic                     n_w     [NCH];
  logic signed [CNT_W+1:0]  dd_w    [NCH];

  assign ch_samp[0] = mono ? $signed(samp_r) : $signed(samp_l);
  assign ch_samp[1] = $signed(samp_r);

  fpwm_carrier #(
    .CNT_W (CNT_W),
    .HALF  (HALF),
    .DITH_W(DITH_W),
    .LFSR_W(LFSR_W)
  ) carrier_i (
    .clk    (clk),
    .rst    (rst),
    .fix_i  (freq_fixed),
    .t_o    (t_w),
    .m_o    (m_w),
    .dir_o  (dir_w),
    .bound_o(bound_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fpwm_chan #(
      .CNT_W (CNT_W),
      .SAMP_W(SAMP_W)
    ) chan_i (
      .clk   (clk),
      .rst   (rst),
      .load_i(bound_w),
      .en_i  (enable),
      .samp_i(ch_samp[c]),
      .m_i   (m_w),
      .t_i   (t_w),
      .dir_i (dir_w),
      .p_o   (p_w[c]),
      .n_o   (n_w[c]),
      .dd_o  (dd_w[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      ddv_q  <= 1'b0;
      mono_q <= 1'b0;
    end else begin
      oe_q  <= enable;
      ddv_q <= bound_w;
      if (bound_w) mono_q <= mono;
    end
  end

  assign pwm_lp    = p_w[0];
  assign pwm_ln    = n_w[0];
  assign pwm_rp    = p_w[1];
  assign pwm_rn    = n_w[1];
  assign dd_l      = dd_w[0];
  assign dd_r      = dd_w[1];
  assign bridge_oe = oe_q;
  assign dd_valid  = ddv_q;

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bridge_oe |-> !(pwm_lp | pwm_ln | pwm_rp | pwm_rn));  // R9
  AST_MONO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (mono_q && $past(mono_q)) |-> (pwm_lp == pwm_rp && pwm_ln == pwm_rn));  // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dd_valid |=> !dd_valid);  // R10
endmodule

// File: tb/fpwm_bridge_mod_tb.sv
module fpwm_bridge_mod_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int HP = 32;
  localparam int MAXL = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, freq_fixed = 1'b1, mono = 1'b0;
  logic [7:0] samp_l = '0, samp_r = '0;
  logic pwm_lp, pwm_ln, pwm_rp, pwm_rn, bridge_oe, dd_valid;
  logic [CW+1:0] dd_l, dd_r;

  int checks = 0;
  int fails = 0;

  int len, ddl_v, ddr_v;
  bit wlp [MAXL];
  bit wln [MAXL];
  bit wrp [MAXL];
  bit wrn [MAXL];

  always #(CLK_PERIOD/2) clk = ~clk;

  fpwm_bridge_mod #(
    .CNT_W (CW),
    .HALF  (HP),
    .SAMP_W(8),
    .DITH_W(4),
    .LFSR_W(16)
  ) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .freq_fixed(freq_fixed), .mono(mono),
    .samp_l(samp_l), .samp_r(samp_r),
    .pwm_lp(pwm_lp), .pwm_ln(pwm_ln), .pwm_rp(pwm_rp), .pwm_rn(pwm_rn),
    .bridge_oe(bridge_oe), .dd_l(dd_l), .dd_r(dd_r), .dd_valid(dd_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int hi);
    return (v < 0) ? 0 : ((v > hi) ? hi : v);
  endfunction

  function automatic bit exp_bit(input int j, input int l, input int d);
    int m;
    m = l / 2;
    if (j < m) return j < (d + 1) / 2;
    return (l - 1 - j) < d / 2;
  endfunction

  // Capture one full output period, from the cycle after a strobe up to the next strobe.
  task automatic meas(input bit chg, input int cl, input int cr);
    @(negedge clk);
    while (!dd_valid) @(negedge clk);
    len = 0;
    do begin
      @(negedge clk);
      if (len < MAXL) begin
        wlp[len] = pwm_lp; wln[len] = pwm_ln; wrp[len] = pwm_rp; wrn[len] = pwm_rn;
      end
      len++;
      if (chg && len == HP) begin
        samp_l = 8'(cl);
        samp_r = 8'(cr);
      end
    end while (!dd_valid && len < MAXL);
    ddl_v = int'($signed(dd_l));
    ddr_v = int'($signed(dd_r));
  endtask

  task automatic eval(input int sl, input int sr, input string tag);
    int m, epl, enl, epr, enr, cpl, cnl, cpr, cnr, mis;
    m = len / 2;
    epl = sat(m + sl, 2*m); enl = sat(m - sl, 2*m);
    epr = sat(m + sr, 2*m); enr = sat(m - sr, 2*m);
    cpl = 0; cnl = 0; cpr = 0; cnr = 0; mis = 0;
    for (int j = 0; j < len && j < MAXL; j++) begin
      cpl += int'(wlp[j]); cnl += int'(wln[j]); cpr += int'(wrp[j]); cnr += int'(wrn[j]);
      if (wlp[j] != exp_bit(j, len, epl)) mis++;
      if (wln[j] != exp_bit(j, len, enl)) mis++;
      if (wrp[j] != exp_bit(j, len, epr)) mis++;
      if (wrn[j] != exp_bit(j, len, enr)) mis++;
    end
    chk(cpl == epl, {"R3 left P duty ", tag}, cpl, epl);
    chk(cnl == enl, {"R3 left N duty ", tag}, cnl, enl);
    chk(cpr == epr, {"R3 right P duty ", tag}, cpr, epr);
    chk(cnr == enr, {"R3 right N duty ", tag}, cnr, enr);
    chk(mis == 0, {"R4 centred pulse shape ", tag}, mis, 0);
    chk(ddl_v == epl - enl, {"R10 left difference ", tag}, ddl_v, epl - enl);
    chk(ddr_v == epr - enr, {"R10 right difference ", tag}, ddr_v, epr - enr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int first_len, diff_seen, mis;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk({pwm_lp, pwm_ln, pwm_rp, pwm_rn} == 4'b0, "R1 data outputs in reset",
        int'({pwm_lp, pwm_ln, pwm_rp, pwm_rn}), 0);
    chk(bridge_oe == 1'b0 && dd_valid == 1'b0, "R1 enable and strobe in reset",
        int'({bridge_oe, dd_valid}), 0);
    chk(dd_l == '0 && dd_r == '0, "R1 differences in reset", int'(dd_l) + int'(dd_r), 0);
    rst = 1'b0;
    enable = 1'b1;

    // R2 and R5: zero input, fixed period
    meas(0, 0, 0); meas(0, 0, 0);
    chk(len == 2*HP, "R5 fixed period length", len, 2*HP);
    mis = 0;
    for (int j = 0; j < len; j++) if (wlp[j] != wln[j] || wrp[j] != wrn[j] || wlp[j] != wrp[j]) mis++;
    chk(mis == 0, "R2 zero input in phase", mis, 0);
    eval(0, 0, "zero");

    // R3 R4 R5 R10: exhaustive sample sweep
    for (int s = -128; s < 128; s++) begin
      samp_l = 8'(s);
      samp_r = 8'(-s - 1);
      meas(0, 0, 0); meas(0, 0, 0);
      chk(len == 2*HP, "R5 fixed period in sweep", len, 2*HP);
      eval(s, -s - 1, "sweep");
    end

    // R7: mid-period change is held off to the next period
    samp_l = 8'(40); samp_r = 8'(-9);
    meas(0, 0, 0); meas(0, 0, 0);
    meas(1, -20, 13);
    eval(40, -9, "R7 period with mid change");
    meas(0, 0, 0);
    eval(-20, 13, "R7 following period");

    // R8: mono
    mono = 1'b1; samp_l = 8'(50); samp_r = 8'(-7);
    meas(0, 0, 0); meas(0, 0, 0);
    eval(-7, -7, "R8 mono");
    chk(ddl_v == ddr_v, "R8 mono differences equal", ddl_v, ddr_v);
    mono = 1'b0;

    // R6: spread spectrum
    freq_fixed = 1'b0; samp_l = 8'(5); samp_r = 8'(0);
    meas(0, 0, 0); meas(0, 0, 0);
    first_len = len; diff_seen = 0;
    for (int k = 0; k < 24; k++) begin
      meas(0, 0, 0);
      chk(len % 2 == 0 && len >= 2*(HP-8) && len <= 2*(HP+7), "R6 dithered period range", len, 2*HP);
      if (len != first_len) diff_seen = 1;
      eval(5, 0, "R6 dithered");
      mis = 0;
      for (int j = 0; j < len; j++) if (wrp[j] != wrn[j]) mis++;
      chk(mis == 0, "R2 zero input in phase while dithered", mis, 0);
    end
    chk(diff_seen == 1, "R6 period length varies", diff_seen, 1);
    freq_fixed = 1'b1;
    meas(0, 0, 0); meas(0, 0, 0);
    chk(len == 2*HP, "R5 fixed period restored", len, 2*HP);

    // R9: enable
    samp_l = 8'(20); samp_r = 8'(-20);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(bridge_oe == 1'b0, "R9 pad enable drops", int'(bridge_oe), 0);
    mis = 0;
    for (int j = 0; j < 150; j++) begin
      if (pwm_lp | pwm_ln | pwm_rp | pwm_rn) mis++;
      @(negedge clk);
    end
    chk(mis == 0, "R9 outputs parked low", mis, 0);
    enable = 1'b1;
    @(negedge clk);
    chk(bridge_oe == 1'b1, "R9 pad enable returns", int'(bridge_oe), 1);
    meas(0, 0, 0); meas(0, 0, 0);
    eval(20, -20, "R9 after re-enable");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule